// File: doc/BRIEF.md
# Hashed-Index Set-Associative Tag Cache with Victim Buffer

This block tracks which memory lines are present in a set-associative cache. It records tags only and holds no data. Each request carries a line address. The block decides whether that line sits in the primary array, sits in a small victim buffer, or is absent. It then updates its replacement state so that the next request sees the result.

The set is not taken from the plain low bits of the address. It comes from an XOR fold of two adjacent address fields. This spreads out strided patterns that would otherwise pile up in one set. Within a set, ways are ranked from most to least recently used. A line pushed out of a set is not lost at once. It drops into a fully associative victim buffer, which is also ranked by recency, and a later request can pull it back into its set.

Three saturating counters accumulate the number of primary hits, victim hits and misses. These counters give a running picture of conflict behaviour for a given hash and geometry.

Top module: `hashed_victim_cache`

## Requirements
- R1: After reset, respValid is low and all three counters read zero. No line is present, so the first request to any address reports a miss.
- R2: A request presented with reqValid high at a rising clock edge is answered after that edge and holds until the next edge. The answer is respValid high together with exactly one of respHit, respVicHit and respMiss.
- R3: The set index is reqAddr[SET_W-1:0] XOR reqAddr[2*SET_W-1:SET_W]. Only that one set is searched, and a line can occupy only that set.
- R4: A primary hit makes the line the most recently used (MRU) line of its set. When a set is full, the least recently used (LRU) way is the one that gets replaced.
- R5: On a miss, the requested line is installed as the MRU line of its set. If the replaced way held a valid line, that line is inserted into the victim buffer as its most recently used entry.
- R6: The victim buffer holds VICT lines and is searched across all entries. When it is full and a new line enters, its least recently used entry is discarded and can no longer be found.
- R7: On a victim hit, the line returns to its set as the MRU line. The set's LRU line takes the vacated victim entry and becomes that buffer's most recently used entry.
- R8: A line is never present in both the primary array and the victim buffer. At most one way of a set, and at most one victim entry, matches any address.
- R9: hitCount, vicHitCount and missCount each rise by one for their own outcome. Each stops at its all-ones value.
- R10: A cycle with reqValid low changes nothing. No response is raised, no counter moves, and no line is installed for the address present on reqAddr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | ADDR_W | Line address of the request |
| respValid | output | 1 | Registered response present |
| respHit | output | 1 | Line found in the primary array |
| respVicHit | output | 1 | Line found in the victim buffer |
| respMiss | output | 1 | Line found nowhere |
| hitCount | output | CNT_W | Saturating count of primary hits |
| vicHitCount | output | CNT_W | Saturating count of victim hits |
| missCount | output | CNT_W | Saturating count of misses |

## Verification
The bench builds the block with an 8-bit address, four sets, two ways, two victim entries and 4-bit counters. With two ways, a third line mapped to a set forces an eviction after a few requests. With two victim entries, the buffer overflows, so entry discard and the LRU order of the buffer can be observed after only a handful of evictions. With four sets, address pairs can be chosen that a plain modulo index would place together but the XOR fold keeps apart, and the reverse, which separates the hash from a plain modulo index. The 4-bit counters reach saturation within twenty requests.

// File: rtl/hvc_pkg.sv
package hvc_pkg;

  // Strobes from control to the tag store, at most one high per cycle
  typedef struct packed {
    logic primHit;  // refresh recency of the matching way
    logic vicHit;   // swap a victim line back into its set
    logic fill;     // install a missing line
  } cacheOps_t;

endpackage

// File: rtl/hvc_tag_store.sv
module hvc_tag_store
  import hvc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int SET_W  = 7,
  parameter int WAYS   = 4,
  parameter int VICT   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  cacheOps_t         ops,
  output logic              primHitRaw,
  output logic              vicHitRaw
);

  localparam int SETS   = 1 << SET_W;
  localparam int AGE_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int WAY_IW = AGE_W;
  localparam int VAGE_W = (VICT > 1) ? $clog2(VICT) : 1;
  localparam int VIDX_W = VAGE_W;

  // Primary array
  logic [ADDR_W-1:0] pLine [SETS][WAYS];
  logic [WAYS-1:0]   pVal  [SETS];
  logic [AGE_W-1:0]  pAge  [SETS][WAYS];

  // Victim buffer
  logic [ADDR_W-1:0] vLine [VICT];
  logic [VICT-1:0]   vVal;
  logic [VAGE_W-1:0] vAge  [VICT];

  logic [SET_W-1:0]  setIdx;
  logic [WAYS-1:0]   wayMatch;
  logic [WAY_IW-1:0] hitWay, repWay, pTouchWay;
  logic              freeWay;
  logic [VICT-1:0]   vicMatch;
  logic [VIDX_W-1:0] vHitSlot, vFreeSlot, vTouchSlot;
  logic              freeSlot;
  logic [ADDR_W-1:0] evLine;
  logic              evValid;
  logic              pTouch, vTouch;

  // XOR fold of two adjacent address fields selects the set
  assign setIdx = reqAddr[SET_W-1:0] ^ reqAddr[2*SET_W-1:SET_W];

  // Primary lookup and replacement choice
  always_comb begin
    wayMatch = '0;
    hitWay   = '0;
    repWay   = '0;
    freeWay  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      wayMatch[w] = pVal[setIdx][w] && (pLine[setIdx][w] == reqAddr);
      if (wayMatch[w]) hitWay = WAY_IW'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!pVal[setIdx][w]) begin
        repWay  = WAY_IW'(w);
        freeWay = 1'b1;
      end
    end
    if (!freeWay) begin
      for (int w = 0; w < WAYS; w++) begin
        if (pAge[setIdx][w] == AGE_W'(WAYS - 1)) repWay = WAY_IW'(w);
      end
    end
  end

  // Victim lookup and insertion slot choice
  always_comb begin
    vicMatch  = '0;
    vHitSlot  = '0;
    vFreeSlot = '0;
    freeSlot  = 1'b0;
    for (int v = 0; v < VICT; v++) begin
      vicMatch[v] = vVal[v] && (vLine[v] == reqAddr);
      if (vicMatch[v]) vHitSlot = VIDX_W'(v);
    end
    for (int v = VICT - 1; v >= 0; v--) begin
      if (!vVal[v]) begin
        vFreeSlot = VIDX_W'(v);
        freeSlot  = 1'b1;
      end
    end
    if (!freeSlot) begin
      for (int v = 0; v < VICT; v++) begin
        if (vAge[v] == VAGE_W'(VICT - 1)) vFreeSlot = VIDX_W'(v);
      end
    end
  end

  assign primHitRaw = |wayMatch;
  assign vicHitRaw  = |vicMatch;
  assign evLine     = pLine[setIdx][repWay];
  assign evValid    = pVal[setIdx][repWay];

  assign pTouch     = ops.primHit | ops.vicHit | ops.fill;
  assign pTouchWay  = ops.primHit ? hitWay : repWay;
  assign vTouch     = ops.vicHit | (ops.fill & evValid);
  assign vTouchSlot = ops.vicHit ? vHitSlot : vFreeSlot;

  // Line addresses need no reset; valid bits guard them
  always_ff @(posedge clk) begin
    if (rstN) begin
      if (ops.vicHit || ops.fill) pLine[setIdx][repWay] <= reqAddr;
      if (ops.vicHit) vLine[vHitSlot] <= evLine;
      else if (ops.fill && evValid) vLine[vFreeSlot] <= evLine;
    end
  end

  // Valid bits and recency ranks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        pVal[s] <= '0;
        for (int w = 0; w < WAYS; w++) pAge[s][w] <= AGE_W'(w);
      end
      vVal <= '0;
      for (int v = 0; v < VICT; v++) vAge[v] <= VAGE_W'(v);
    end else begin
      if (ops.vicHit || ops.fill) pVal[setIdx][repWay] <= 1'b1;
      if (pTouch) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_IW'(w) == pTouchWay)
            pAge[setIdx][w] <= '0;
          else if (pAge[setIdx][w] < pAge[setIdx][pTouchWay])
            pAge[setIdx][w] <= pAge[setIdx][w] + 1'b1;
        end
      end
      if (ops.vicHit) vVal[vHitSlot] <= evValid;
      else if (ops.fill && evValid) vVal[vFreeSlot] <= 1'b1;
      if (vTouch) begin
        for (int v = 0; v < VICT; v++) begin
          if (VIDX_W'(v) == vTouchSlot)
            vAge[v] <= '0;
          else if (vAge[v] < vAge[vTouchSlot])
            vAge[v] <= vAge[v] + 1'b1;
        end
      end
    end
  end

  // R8: the two stores never both hold the requested line
  a_r8_exclusive_stores: assert property (@(posedge clk) disable iff (!rstN)
    primHitRaw |-> !vicHitRaw);

  // R8: no duplicate line within the probed set
  a_r8_single_way_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wayMatch));

  // R8: no duplicate line within the victim buffer
  a_r8_single_victim_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(vicMatch));

  // R6: victim occupancy never drops once entries arrive
  a_r6_victim_no_shrink: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($countones(vVal) >= $past($countones(vVal))));

endmodule

// File: rtl/hvc_ctrl.sv
module hvc_ctrl
  import hvc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             primHitRaw,
  input  logic             vicHitRaw,
  output cacheOps_t        ops,
  output logic             respValid,
  output logic             respHit,
  output logic             respVicHit,
  output logic             respMiss,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] vicHitCount,
  output logic [CNT_W-1:0] missCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Primary result wins; victim only consulted on a primary miss
  always_comb begin
    ops.primHit = reqValid & primHitRaw;
    ops.vicHit  = reqValid & ~primHitRaw & vicHitRaw;
    ops.fill    = reqValid & ~primHitRaw & ~vicHitRaw;
  end

  function automatic logic [CNT_W-1:0] satInc(input logic [CNT_W-1:0] c,
                                              input logic en);
    return (en && c != CNT_MAX) ? c + 1'b1 : c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid   <= 1'b0;
      respHit     <= 1'b0;
      respVicHit  <= 1'b0;
      respMiss    <= 1'b0;
      hitCount    <= '0;
      vicHitCount <= '0;
      missCount   <= '0;
    end else begin
      respValid   <= reqValid;
      respHit     <= ops.primHit;
      respVicHit  <= ops.vicHit;
      respMiss    <= ops.fill;
      hitCount    <= satInc(hitCount, ops.primHit);
      vicHitCount <= satInc(vicHitCount, ops.vicHit);
      missCount   <= satInc(missCount, ops.fill);
    end
  end

  // R2: a request is answered on the following cycle, idle gives no answer
  a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);
  a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);

  // R9: a saturated counter stays put
  a_r9_hit_saturates: assert property (@(posedge clk) disable iff (!rstN)
    (hitCount == CNT_MAX) |=> (hitCount == CNT_MAX));
  a_r9_miss_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (missCount >= $past(missCount)));

  // R10: idle cycles leave every counter unchanged
  a_r10_idle_counters: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(hitCount) && $stable(vicHitCount) && $stable(missCount)));

endmodule

// File: rtl/hashed_victim_cache.sv
module hashed_victim_cache
  import hvc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int SET_W  = 7,
  parameter int WAYS   = 4,
  parameter int VICT   = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              respValid,
  output logic              respHit,
  output logic              respVicHit,
  output logic              respMiss,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  vicHitCount,
  output logic [CNT_W-1:0]  missCount
);

  cacheOps_t ops;
  logic      primHitRaw;
  logic      vicHitRaw;

  hvc_tag_store #(
    .ADDR_W(ADDR_W), .SET_W(SET_W), .WAYS(WAYS), .VICT(VICT)
  ) i_store (
    .clk       (clk),
    .rstN      (rstN),
    .reqAddr   (reqAddr),
    .ops       (ops),
    .primHitRaw(primHitRaw),
    .vicHitRaw (vicHitRaw)
  );

  hvc_ctrl #(
    .CNT_W(CNT_W)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .primHitRaw (primHitRaw),
    .vicHitRaw  (vicHitRaw),
    .ops        (ops),
    .respValid  (respValid),
    .respHit    (respHit),
    .respVicHit (respVicHit),
    .respMiss   (respMiss),
    .hitCount   (hitCount),
    .vicHitCount(vicHitCount),
    .missCount  (missCount)
  );

endmodule

// File: tb/test_hashed_victim_cache.sv
module test_hashed_victim_cache;

  localparam int ADDR_W = 8;
  localparam int SET_W  = 2;
  localparam int WAYS   = 2;
  localparam int VICT   = 2;
  localparam int CNT_W  = 4;
  localparam int K_HIT = 0, K_VIC = 1, K_MISS = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              respValid, respHit, respVicHit, respMiss;
  logic [CNT_W-1:0]  hitCount, vicHitCount, missCount;

  int  nTests = 0;
  int  nFail  = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  hashed_victim_cache #(
    .ADDR_W(ADDR_W), .SET_W(SET_W), .WAYS(WAYS), .VICT(VICT), .CNT_W(CNT_W)
  ) i_hashed_victim_cache (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .respValid(respValid), .respHit(respHit), .respVicHit(respVicHit),
    .respMiss(respMiss), .hitCount(hitCount), .vicHitCount(vicHitCount),
    .missCount(missCount)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    reqValid = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(respValid == 1'b0, "R1 respValid after reset", respValid, 0);
    check(hitCount == 0 && vicHitCount == 0 && missCount == 0,
          "R1 counters after reset", hitCount + vicHitCount + missCount, 0);
  endtask

  // Drive at a falling edge, sample the registered answer at the next one
  task automatic access(input logic [ADDR_W-1:0] a, input int expKind, input string req);
    int kind;
    reqValid = 1'b1;
    reqAddr  = a;
    @(negedge clk);
    reqValid = 1'b0;
    kind = respHit ? K_HIT : respVicHit ? K_VIC : respMiss ? K_MISS : 3;
    check(respValid && (int'(respHit) + int'(respVicHit) + int'(respMiss) == 1),
          "R2 single outcome", int'(respHit) + int'(respVicHit) + int'(respMiss), 1);
    check(kind == expKind, req, kind, expKind);
  endtask

  task automatic chkCounts(input int h, input int v, input int m, input string req);
    check(hitCount == CNT_W'(h), {req, " hitCount"}, hitCount, h);
    check(vicHitCount == CNT_W'(v), {req, " vicHitCount"}, vicHitCount, v);
    check(missCount == CNT_W'(m), {req, " missCount"}, missCount, m);
  endtask

  // Ping-pong across two different sets
  task automatic testPingPong();
    doReset();
    access(8'h00, K_MISS, "R1 cold miss a");
    access(8'h01, K_MISS, "R5 cold miss b");
    access(8'h00, K_HIT,  "R4 ping-pong hit a");
    access(8'h01, K_HIT,  "R4 ping-pong hit b");
    chkCounts(2, 0, 2, "R9 ping-pong");
  endtask

  // Hash groups differ from modulo groups
  task automatic testHash();
    doReset();
    access(8'h00, K_MISS, "R3 fill 00");
    access(8'h04, K_MISS, "R3 fill 04");
    access(8'h08, K_MISS, "R3 fill 08");
    access(8'h0C, K_MISS, "R3 fill 0C");
    access(8'h00, K_HIT,  "R3 00 kept in own set");
    access(8'h04, K_HIT,  "R3 04 kept in own set");
    access(8'h08, K_HIT,  "R3 08 kept in own set");
    access(8'h0C, K_HIT,  "R3 0C kept in own set");
    doReset();
    access(8'h00, K_MISS, "R3 fill 00");
    access(8'h05, K_MISS, "R3 fill 05 same hashed set");
    access(8'h0A, K_MISS, "R3 fill 0A same hashed set");
    access(8'h00, K_VIC,  "R3 00 pushed out by hashed conflict");
  endtask

  // Recency inside a set and swap with the victim buffer
  task automatic testLru();
    doReset();
    access(8'h00, K_MISS, "R5 A");
    access(8'h05, K_MISS, "R5 B");
    access(8'h00, K_HIT,  "R4 A refresh");
    access(8'h0A, K_MISS, "R4 C evicts LRU B");
    access(8'h00, K_HIT,  "R4 A survived");
    access(8'h05, K_VIC,  "R7 B from victim");
    access(8'h0A, K_VIC,  "R7 C displaced into victim");
    access(8'h00, K_VIC,  "R7 A displaced into victim");
    chkCounts(2, 3, 3, "R9 lru");
  endtask

  // Victim capacity and its own LRU order
  task automatic testVictimCapacity();
    doReset();
    access(8'h00, K_MISS, "R5 fill 00");
    access(8'h05, K_MISS, "R5 fill 05");
    access(8'h0A, K_MISS, "R5 fill 0A");
    access(8'h0F, K_MISS, "R5 fill 0F");
    access(8'h10, K_MISS, "R6 fill 10 overflows victim");
    access(8'h05, K_VIC,  "R6 05 kept in victim");
    access(8'h00, K_MISS, "R6 00 discarded as victim LRU");
    access(8'h0F, K_VIC,  "R6 0F kept as victim MRU");
    access(8'h0A, K_MISS, "R6 0A discarded");
    chkCounts(0, 2, 7, "R9 victim");
  endtask

  task automatic testSaturation();
    doReset();
    access(8'h00, K_MISS, "R9 prime");
    for (int i = 0; i < 17; i++) access(8'h00, K_HIT, "R9 repeat hit");
    chkCounts(15, 0, 1, "R9 saturated");
  endtask

  task automatic testIdle();
    doReset();
    reqAddr = 8'h05;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(respValid == 1'b0, "R10 no response when idle", respValid, 0);
    end
    chkCounts(0, 0, 0, "R10 idle");
    access(8'h05, K_MISS, "R10 idle address not installed");
    repeat (2) @(negedge clk);
    check(respValid == 1'b0, "R2 response drops", respValid, 0);
    chkCounts(0, 0, 1, "R10 idle after access");
  endtask

  initial begin
    testPingPong();
    testHash();
    testLru();
    testVictimCapacity();
    testSaturation();
    testIdle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule